// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker fetches one 64-bit entry from a table held in memory, selected by a small identifier such as a device or collection number. A table is laid out in one of two ways. A flat table is a plain array of entries. An indirect table starts with an array of 8-byte pointer words, and each pointer word names a second-level page that holds the entries. The requester supplies the identifier, the table base, the page size and entry size (each as a base-2 logarithm), and the flat/indirect choice. The walker then reads memory through a single-outstanding 64-bit read port and returns the entry together with a hit flag and a fault flag.

Only one walk is in progress at a time. The block reports busy from acceptance until completion. It ends each walk with a one-cycle completion strobe, and the result stays registered on its outputs until the next walk completes. Because both sizes are powers of two, every divide and remainder in the indexing becomes a shift or a mask.

Top module: `xlat_table_walker`

## Requirements
- R1: Flat mode issues exactly one read, at base + id * 2^entry_log2, and the walk then completes.
- R2: Indirect mode first reads the pointer word at base + (id / (2^page_log2 / 8)) * 8.
- R3: A pointer word whose bit 63 is 0 ends the walk after that single read. The completion then reports hit=0, fault=0 and entry=0.
- R4: When bit 63 of the pointer word is 1, the second read goes to P + (id mod (2^page_log2 / 2^entry_log2)) * 2^entry_log2. P is bits [50:0] of the pointer word, zero-extended, so bits 51 to 63 do not contribute.
- R5: The final read's data is returned unchanged as the entry. Hit equals bit 0 of that data.
- R6: A read returned with the error flag at either level stops the walk immediately, with no further read. The completion then reports fault=1, hit=0 and entry=0.
- R7: A request is accepted only while busy is low. A request presented while busy is ignored and changes neither the reads issued nor the result.
- R8: The completion strobe lasts exactly one cycle. The entry, hit and fault outputs change only at a completion and hold their values between completions.
- R9: A read request stays asserted with a stable address until the port accepts it.
- R10: A walk issues at least one and at most two reads. A flat walk issues exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request, taken when busy is low |
| req_id | input | ID_W | Identifier that selects the entry |
| req_base | input | ADDR_W | Table base byte address |
| req_page_log2 | input | LOG_W | log2 of the second-level page size in bytes |
| req_entry_log2 | input | LOG_W | log2 of the entry size in bytes (at least 3) |
| req_indirect | input | 1 | 1 selects the two-level layout, 0 the flat layout |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion strobe |
| res_entry | output | 64 | Entry read at the last level, or 0 |
| res_hit | output | 1 | Entry bit 0 was set and no fault occurred |
| res_fault | output | 1 | The walk ended on a read error |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data, little-endian 64-bit word |
| mem_rsp_err | input | 1 | Read returned an error |

## Verification
Several properties are checked on every cycle. A stalled read request must hold its address. The completion strobe must not repeat, and the result outputs must stay frozen between completions. A cleared pointer bit or an error response must lead, one cycle later, to a completion with the matching flags, and the read count per walk must stay within its budget. Address arithmetic cannot be checked that way, so the bench checks it with a behavioural model that uses true division and remainder. The bench scenarios also cover the masking of high pointer bits, a request dropped while busy, and the interaction of port back-pressure with response latency.

// File: rtl/xtw_pkg.sv
package xtw_pkg;
    localparam int ENTRY_W       = 64;
    localparam int PTR_W         = 51;
    localparam int PTR_VALID_BIT = 63;
    localparam int HIT_BIT       = 0;
    localparam int PTR_WORD_LOG2 = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_REQ,
        S_PTR_WAIT,
        S_LEAF_REQ,
        S_LEAF_WAIT,
        S_DONE
    } walk_state_t;

    typedef struct packed {
        logic [ENTRY_W-1:0] entry;
        logic               hit;
        logic               fault;
    } walk_result_t;

    localparam walk_result_t RESULT_NONE  = '{entry: '0, hit: 1'b0, fault: 1'b0};
    localparam walk_result_t RESULT_FAULT = '{entry: '0, hit: 1'b0, fault: 1'b1};
endpackage

// File: rtl/xtw_addr_calc.sv
module xtw_addr_calc
    import xtw_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int ADDR_W = 64,
    parameter int LOG_W  = 6
) (
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] base,
    input  logic [LOG_W-1:0]  page_log2,
    input  logic [LOG_W-1:0]  entry_log2,
    input  logic [PTR_W-1:0]  page_ptr,
    output logic [ADDR_W-1:0] flat_addr,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] leaf_addr
);
    localparam logic [LOG_W-1:0] PTR_LOG = LOG_W'(PTR_WORD_LOG2);

    logic [ADDR_W-1:0] id_ext;
    logic [LOG_W-1:0]  ptr_shift;
    logic [LOG_W-1:0]  span_log2;
    logic [ADDR_W-1:0] ptr_index;
    logic [ADDR_W-1:0] leaf_index;
    logic [ADDR_W-1:0] page_base;

    always_comb begin
        id_ext     = ADDR_W'(id);
        ptr_shift  = page_log2 - PTR_LOG;
        span_log2  = page_log2 - entry_log2;
        ptr_index  = id_ext >> ptr_shift;
        leaf_index = id_ext & ~({ADDR_W{1'b1}} << span_log2);
        page_base  = ADDR_W'(page_ptr);
        flat_addr  = base + (id_ext << entry_log2);
        ptr_addr   = base + (ptr_index << PTR_LOG);
        leaf_addr  = page_base + (leaf_index << entry_log2);
    end
endmodule

// File: rtl/xtw_walk_ctrl.sv
module xtw_walk_ctrl
    import xtw_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int ADDR_W = 64,
    parameter int LOG_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ID_W-1:0]    req_id,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [LOG_W-1:0]   req_page_log2,
    input  logic [LOG_W-1:0]   req_entry_log2,
    input  logic               req_indirect,
    output logic [ID_W-1:0]    id_q,
    output logic [ADDR_W-1:0]  base_q,
    output logic [LOG_W-1:0]   page_log2_q,
    output logic [LOG_W-1:0]   entry_log2_q,
    output logic [PTR_W-1:0]   page_ptr_q,
    input  logic [ADDR_W-1:0]  flat_addr,
    input  logic [ADDR_W-1:0]  ptr_addr,
    input  logic [ADDR_W-1:0]  leaf_addr,
    output logic               busy_o,
    output logic               done_o,
    output walk_result_t       result_o,
    output logic               mem_req_valid_o,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr_o,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    input  logic               mem_rsp_err
);
    walk_state_t  state_q;
    logic         indirect_q;
    walk_result_t result_q;
    logic [1:0]   rd_cnt_q;
    logic         rd_fire;

    assign rd_fire = mem_req_valid_o && mem_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            indirect_q   <= 1'b0;
            id_q         <= '0;
            base_q       <= '0;
            page_log2_q  <= '0;
            entry_log2_q <= '0;
            page_ptr_q   <= '0;
            result_q     <= RESULT_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        id_q         <= req_id;
                        base_q       <= req_base;
                        page_log2_q  <= req_page_log2;
                        entry_log2_q <= req_entry_log2;
                        indirect_q   <= req_indirect;
                        state_q      <= req_indirect ? S_PTR_REQ : S_LEAF_REQ;
                    end
                end
                S_PTR_REQ: begin
                    if (mem_req_ready) state_q <= S_PTR_WAIT;
                end
                S_PTR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            result_q <= RESULT_FAULT;
                            state_q  <= S_DONE;
                        end else if (!mem_rsp_data[PTR_VALID_BIT]) begin
                            result_q <= RESULT_NONE;
                            state_q  <= S_DONE;
                        end else begin
                            page_ptr_q <= mem_rsp_data[PTR_W-1:0];
                            state_q    <= S_LEAF_REQ;
                        end
                    end
                end
                S_LEAF_REQ: begin
                    if (mem_req_ready) state_q <= S_LEAF_WAIT;
                end
                S_LEAF_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            result_q <= RESULT_FAULT;
                        end else begin
                            result_q.entry <= mem_rsp_data;
                            result_q.hit   <= mem_rsp_data[HIT_BIT];
                            result_q.fault <= 1'b0;
                        end
                        state_q <= S_DONE;
                    end
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Read counter kept for the budget checks below.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt_q <= '0;
        end else if (state_q == S_IDLE) begin
            rd_cnt_q <= '0;
        end else if (rd_fire && rd_cnt_q != 2'd3) begin
            rd_cnt_q <= rd_cnt_q + 2'd1;
        end
    end

    always_comb begin
        busy_o          = (state_q != S_IDLE);
        done_o          = (state_q == S_DONE);
        result_o        = result_q;
        mem_req_valid_o = (state_q == S_PTR_REQ) || (state_q == S_LEAF_REQ);
        if (state_q == S_PTR_REQ)
            mem_req_addr_o = ptr_addr;
        else
            mem_req_addr_o = indirect_q ? leaf_addr : flat_addr;
    end

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    a_r3_ptr_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PTR_WAIT && mem_rsp_valid && !mem_rsp_err && !mem_rsp_data[PTR_VALID_BIT])
        |=> (done_o && !result_o.hit && !result_o.fault && !mem_req_valid_o));

    a_r6_abort: assert property (@(posedge clk) disable iff (rst)
        ((state_q == S_PTR_WAIT || state_q == S_LEAF_WAIT) && mem_rsp_valid && mem_rsp_err)
        |=> (done_o && result_o.fault && !result_o.hit && !mem_req_valid_o));

    a_r5_hit_bit: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o.hit) |-> (result_o.entry[HIT_BIT] && !result_o.fault));

    a_r10_read_budget: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rd_cnt_q == 2'd1 || rd_cnt_q == 2'd2));

    a_r10_flat_once: assert property (@(posedge clk) disable iff (rst)
        (done_o && !indirect_q) |-> (rd_cnt_q == 2'd1));
endmodule

// File: rtl/xlat_table_walker.sv
module xlat_table_walker
    import xtw_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int ADDR_W = 64,
    parameter int LOG_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [LOG_W-1:0]  req_page_log2,
    input  logic [LOG_W-1:0]  req_entry_log2,
    input  logic              req_indirect,
    output logic              busy,
    output logic              done,
    output logic [63:0]       res_entry,
    output logic              res_hit,
    output logic              res_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err
);
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] base_q;
    logic [LOG_W-1:0]  page_log2_q;
    logic [LOG_W-1:0]  entry_log2_q;
    logic [PTR_W-1:0]  page_ptr_q;
    logic [ADDR_W-1:0] flat_addr;
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] leaf_addr;
    walk_result_t      result;

    xtw_addr_calc #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_addr (
        .id         (id_q),
        .base       (base_q),
        .page_log2  (page_log2_q),
        .entry_log2 (entry_log2_q),
        .page_ptr   (page_ptr_q),
        .flat_addr  (flat_addr),
        .ptr_addr   (ptr_addr),
        .leaf_addr  (leaf_addr)
    );

    xtw_walk_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_id          (req_id),
        .req_base        (req_base),
        .req_page_log2   (req_page_log2),
        .req_entry_log2  (req_entry_log2),
        .req_indirect    (req_indirect),
        .id_q            (id_q),
        .base_q          (base_q),
        .page_log2_q     (page_log2_q),
        .entry_log2_q    (entry_log2_q),
        .page_ptr_q      (page_ptr_q),
        .flat_addr       (flat_addr),
        .ptr_addr        (ptr_addr),
        .leaf_addr       (leaf_addr),
        .busy_o          (busy),
        .done_o          (done),
        .result_o        (result),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .mem_rsp_err     (mem_rsp_err)
    );

    assign res_entry = result.entry;
    assign res_hit   = result.hit;
    assign res_fault = result.fault;
endmodule

// File: tb/xlat_table_walker_tb.sv
module xlat_table_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_id = '0;
    logic [63:0] req_base = '0;
    logic [5:0]  req_page_log2 = '0;
    logic [5:0]  req_entry_log2 = '0;
    logic        req_indirect = 1'b0;
    logic        busy, done, res_hit, res_fault;
    logic [63:0] res_entry;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        mem_rsp_err;

    int tests = 0;
    int fails = 0;

    logic [63:0]     mem [longint unsigned];
    longint unsigned err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
    longint unsigned addr_log [$];
    int              lat = 1;
    bit              stall_en = 1'b0;
    int              cyc = 0;

    logic            pend;
    int              wcnt;
    longint unsigned paddr;

    always #4 clk = ~clk;

    xlat_table_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
        .req_base(req_base), .req_page_log2(req_page_log2),
        .req_entry_log2(req_entry_log2), .req_indirect(req_indirect),
        .busy(busy), .done(done), .res_entry(res_entry), .res_hit(res_hit),
        .res_fault(res_fault), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [63:0] mem_rd(longint unsigned a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // Memory port model: one outstanding read, response after lat cycles.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            pend <= 1'b0; wcnt <= 0; paddr <= 0;
            mem_rsp_valid <= 1'b0; mem_rsp_data <= '0; mem_rsp_err <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                if (wcnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_err   <= (paddr == err_addr);
                    mem_rsp_data  <= (paddr == err_addr) ? 64'hDEAD_BEEF_DEAD_BEEF : mem_rd(paddr);
                    pend <= 1'b0;
                end else begin
                    wcnt <= wcnt - 1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                pend  <= 1'b1;
                wcnt  <= lat;
                paddr <= mem_req_addr;
                addr_log.push_back(mem_req_addr);
            end
        end
    end

    always @(negedge clk) begin
        mem_req_ready <= stall_en ? (cyc % 3 == 2) : 1'b1;
        if (!rst && mem_req_valid && !busy) begin
            tests++; fails++;
            $display("FAIL R7: read request while idle, actual busy=%0b expected 1", busy);
        end
    end

    task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Behavioural reference: true division and remainder on byte sizes.
    task automatic model(input longint unsigned id, base, input int pl2, el2, input bit ind,
                         output logic [63:0] e, output bit v, output bit er, output int n,
                         output longint unsigned a0, output longint unsigned a1);
        longint unsigned page = longint'(1) << pl2;
        longint unsigned esz  = longint'(1) << el2;
        logic [63:0] w;
        e = 0; v = 0; er = 0; a1 = 0; n = 1;
        if (!ind) begin
            a0 = base + id * esz;
            if (a0 == err_addr) er = 1;
            else begin e = mem_rd(a0); v = e[0]; end
        end else begin
            a0 = base + (id / (page / 8)) * 8;
            if (a0 == err_addr) er = 1;
            else begin
                w = mem_rd(a0);
                if (w[63]) begin
                    n  = 2;
                    a1 = (w % (longint'(1) << 51)) + (id % (page / esz)) * esz;
                    if (a1 == err_addr) er = 1;
                    else begin e = mem_rd(a1); v = e[0]; end
                end
            end
        end
    endtask

    task automatic lookup(input longint unsigned id, base, input int pl2, el2, input bit ind,
                          input bit poke_busy, input string rq);
        logic [63:0] e; bit v, er; int n; longint unsigned a0, a1;
        int waited = 0;
        model(id, base, pl2, el2, ind, e, v, er, n, a0, a1);
        addr_log.delete();
        @(negedge clk);
        req_valid = 1; req_id = 16'(id); req_base = base;
        req_page_log2 = 6'(pl2); req_entry_log2 = 6'(el2); req_indirect = ind;
        @(negedge clk);
        if (poke_busy) begin
            req_id = 16'(id + 1); req_base = base + 64'h100; req_indirect = ~ind;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 0;
        while (!done && waited < 200) begin @(negedge clk); waited++; end
        chk(done, rq, {63'd0, done}, 64'd1);
        chk(res_entry == e, rq, res_entry, e);
        chk(res_hit == v && res_fault == er, rq, {62'd0, res_hit, res_fault}, {62'd0, v, er});
        chk(addr_log.size() == n, "R10", 64'(addr_log.size()), 64'(n));
        if (addr_log.size() >= 1) chk(addr_log[0] == a0, rq, addr_log[0], a0);
        if (addr_log.size() >= 2) chk(addr_log[1] == a1, "R4", addr_log[1], a1);
        @(negedge clk);
        chk(!done && !busy, "R8", {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] keep;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !mem_req_valid && res_entry == 0 && !res_hit && !res_fault,
            "R8 reset", {59'd0, busy, done, mem_req_valid, res_hit, res_fault}, 64'd0);

        // R1: flat, 8-byte entries and 16-byte entries
        mem[64'h1028] = 64'h0000_00AB_CDEF_0001;
        lookup(5, 64'h1000, 12, 3, 0, 0, "R1");
        mem[64'h2070] = 64'h1234_5678_9ABC_DEF0;
        lookup(7, 64'h2000, 12, 4, 0, 0, "R5");

        // R2/R4: indirect, high pointer bits set above bit 50 must be masked
        mem[64'h10008] = 64'h8080_0000_0004_0000;
        mem[64'h40F40] = 64'hCAFE_0000_0000_0011;
        lookup(1000, 64'h10000, 12, 3, 1, 0, "R2");
        mem[64'h20010] = 64'hC000_0000_0008_0000;
        mem[64'h802C0] = 64'h0F0F_0F0F_0F0F_0F0E;
        lookup(300, 64'h20000, 10, 4, 1, 0, "R4");

        // R3: pointer word with bit 63 clear
        mem[64'h30000] = 64'h7FFF_FFFF_FFFF_FFFF;
        lookup(3, 64'h30000, 12, 3, 1, 0, "R3");

        // R6: errors at pointer level, leaf level and in flat mode
        err_addr = 64'h10008;
        lookup(1000, 64'h10000, 12, 3, 1, 0, "R6");
        err_addr = 64'h40F40;
        lookup(1000, 64'h10000, 12, 3, 1, 0, "R6");
        err_addr = 64'h1028;
        lookup(5, 64'h1000, 12, 3, 0, 0, "R6");
        err_addr = 64'hFFFF_FFFF_FFFF_FFF8;

        // R7: a request held while busy is ignored
        lat = 4;
        lookup(5, 64'h1000, 12, 3, 0, 1, "R7");
        lookup(1000, 64'h10000, 12, 3, 1, 1, "R7");

        // R9: back-pressure on the read port with longer latency
        stall_en = 1; lat = 2;
        lookup(300, 64'h20000, 10, 4, 1, 0, "R9");
        lookup(7, 64'h2000, 12, 4, 0, 0, "R9");
        stall_en = 0; lat = 1;

        // R8: result holds between completions
        keep = res_entry;
        repeat (5) @(negedge clk);
        chk(res_entry == keep && !res_hit && !res_fault, "R8 hold", res_entry, keep);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule